// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the control-flow state of one wavefront, meaning a group of lanes that execute under a single program counter. It keeps a stack of records. Each record holds a program counter, the PC at which its lanes rejoin, and a mask of the lanes that are active. The record on top drives the wavefront's current PC, its rejoin PC and its execution mask. The other records wait below it until they are needed.

Branch events arrive one per cycle. An unconditional branch either jumps the top record to its target or, when the target is the top record's rejoin point, pops that record. A conditional branch replaces the top record with up to three new records. The first, pushed only when needed, carries the lanes forward to the branch's immediate post-dominator. The second holds the lanes that fall through to the next instruction. The third holds the lanes that take the branch. The taken path is therefore on top and runs first. Every branch raises a one-cycle pulse that tells the fetch stage to discard what it fetched after the branch. A conditional branch whose target is the next instruction is reported as illegal. A branch that would grow the stack beyond its depth, or leave it empty, sets a sticky flag and leaves the stack unchanged.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds exactly one record. `cur_pc` equals `reset_pc`, `cur_rpc` is all ones, `cur_mask` is all ones, and `discard_fetch`, `bad_branch`, `overflow` and `underflow` are all 0.
- R2: When an unconditional branch (`br_valid`=1, `br_cond`=0) has a target different from `cur_rpc`, the next cycle `cur_pc` equals the target and `cur_rpc` and `cur_mask` are unchanged.
- R3: When an unconditional branch has a target equal to `cur_rpc`, the top record is popped and the record below it becomes the current one.
- R4: A legal conditional branch pops the top record. If the popped record's rejoin PC differs from `br_ipdom`, the branch then pushes a record of (`br_ipdom`, old rejoin PC, old mask). If the two are equal, no such record is pushed.
- R5: The taken mask is `br_lane_cond` AND the current mask. The not-taken mask is the current mask AND NOT the taken mask.
- R6: The records are pushed in this order: the rejoin record, then the not-taken record (`cur_pc`+1, `br_ipdom`, not-taken mask), then the taken record (`br_target`, `br_ipdom`, taken mask). Whichever of them is pushed last becomes the current record.
- R7: The not-taken record is pushed only when `cur_pc`+1 differs from `br_ipdom` and the count of taken lanes is strictly below the count of active lanes. The taken record is pushed only when `br_target` differs from `br_ipdom` and at least one lane is taken.
- R8: `discard_fetch` is 1 for exactly the one cycle after every accepted branch event, including an illegal one, and is 0 otherwise.
- R9: A conditional branch with `br_target` equal to `cur_pc`+1 pulses `bad_branch` for one cycle and leaves the stack unchanged.
- R10: When a branch would leave more than DEPTH records, `overflow` is set and stays set until reset, and the stack is unchanged.
- R11: When a branch would leave zero records, `underflow` is set and stays set until reset, and the stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_pc | input | PC_W | PC loaded into the single record at reset |
| br_valid | input | 1 | A branch event is present this cycle |
| br_cond | input | 1 | 1 = conditional branch, 0 = unconditional |
| br_target | input | PC_W | Branch target PC |
| br_ipdom | input | PC_W | Immediate post-dominator PC (used by conditional branches only) |
| br_lane_cond | input | LANES | Per-lane branch condition (used by conditional branches only) |
| cur_pc | output | PC_W | PC of the top record |
| cur_rpc | output | PC_W | Rejoin PC of the top record |
| cur_mask | output | LANES | Execution mask of the top record |
| discard_fetch | output | 1 | One-cycle pulse after every branch |
| bad_branch | output | 1 | One-cycle pulse after an illegal conditional branch |
| overflow | output | 1 | Sticky: a branch would have exceeded the depth |
| underflow | output | 1 | Sticky: a branch would have emptied the stack |

## Verification
The assertions check on every cycle the local effect of each event:
- the discard pulse follows each branch;
- an unconditional jump keeps the rejoin PC and mask;
- a taken record lands on top with the correct mask;
- an illegal branch leaves the top untouched;
- the flags are sticky and freeze the stack when they rise.

Only the bench scenarios can show what lies deeper in the stack. This covers the ordering of the not-taken and rejoin records under the taken one, and the records that are suppressed. The scenarios expose these by popping records one by one through unconditional branches to the rejoin PC. They also cover the overflow and underflow corner cases that follow a nested divergence.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;
   // number of record writes a single branch can perform
   localparam int unsigned WR_PORTS = 3;
   // write-port roles for a conditional branch, in push order
   typedef enum logic [1:0] {
      WP_REJOIN = 2'd0,
      WP_FALL   = 2'd1,
      WP_TAKEN  = 2'd2
   } wr_port_e;
endpackage

// File: rtl/simt_rs_popcnt.sv
module simt_rs_popcnt #(
   parameter int unsigned N = 32,
   localparam int unsigned W = $clog2(N + 1)
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] cnt
);
   logic [W-1:0] part [N+1];
   assign part[0] = '0;
   for (genvar i = 0; i < N; i++) begin : g_acc
      assign part[i+1] = part[i] + W'(vec[i]);
   end
   assign cnt = part[N];
endmodule

// File: rtl/simt_rs_store.sv
module simt_rs_store
   import simt_rs_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PC_W  = 32,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [PC_W-1:0]                    reset_pc,
   input  logic [WR_PORTS-1:0]                wr_en,
   input  logic [WR_PORTS-1:0][IW-1:0]        wr_idx,
   input  logic [WR_PORTS-1:0][PC_W-1:0]      wr_pc,
   input  logic [WR_PORTS-1:0][PC_W-1:0]      wr_rpc,
   input  logic [WR_PORTS-1:0][LANES-1:0]     wr_mask,
   input  logic                               cnt_en,
   input  logic [CW-1:0]                      cnt_d,
   output logic [CW-1:0]                      cnt_q,
   output logic [PC_W-1:0]                    top_pc,
   output logic [PC_W-1:0]                    top_rpc,
   output logic [LANES-1:0]                   top_mask
);
   logic [PC_W-1:0]  pc_q   [DEPTH];
   logic [PC_W-1:0]  rpc_q  [DEPTH];
   logic [LANES-1:0] mask_q [DEPTH];
   logic [CW-1:0]    top_full;
   logic [IW-1:0]    top_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            pc_q[i]   <= '0;
            rpc_q[i]  <= '0;
            mask_q[i] <= '0;
         end
         pc_q[0]   <= reset_pc;
         rpc_q[0]  <= '1;
         mask_q[0] <= '1;
         cnt_q     <= CW'(1);
      end else begin
         for (int p = 0; p < WR_PORTS; p++) begin
            if (wr_en[p]) begin
               pc_q[wr_idx[p]]   <= wr_pc[p];
               rpc_q[wr_idx[p]]  <= wr_rpc[p];
               mask_q[wr_idx[p]] <= wr_mask[p];
            end
         end
         if (cnt_en) cnt_q <= cnt_d;
      end
   end

   assign top_full = cnt_q - CW'(1);
   assign top_idx  = top_full[IW-1:0];
   assign top_pc   = pc_q[top_idx];
   assign top_rpc  = rpc_q[top_idx];
   assign top_mask = mask_q[top_idx];
endmodule

// File: rtl/simt_rs_ctrl.sv
module simt_rs_ctrl
   import simt_rs_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PC_W  = 32,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned SW = $clog2(DEPTH + 4) + 1,
   localparam int unsigned LW = $clog2(LANES + 1)
) (
   input  logic                           br_valid,
   input  logic                           br_cond,
   input  logic [PC_W-1:0]                br_target,
   input  logic [PC_W-1:0]                br_ipdom,
   input  logic [LANES-1:0]               br_lane_cond,
   input  logic [CW-1:0]                  cnt_q,
   input  logic [PC_W-1:0]                top_pc,
   input  logic [PC_W-1:0]                top_rpc,
   input  logic [LANES-1:0]               top_mask,
   output logic [WR_PORTS-1:0]            wr_en,
   output logic [WR_PORTS-1:0][IW-1:0]    wr_idx,
   output logic [WR_PORTS-1:0][PC_W-1:0]  wr_pc,
   output logic [WR_PORTS-1:0][PC_W-1:0]  wr_rpc,
   output logic [WR_PORTS-1:0][LANES-1:0] wr_mask,
   output logic                           cnt_en,
   output logic [CW-1:0]                  cnt_d,
   output logic                           ovf_evt,
   output logic                           unf_evt,
   output logic                           bad_evt
);
   logic [LANES-1:0] taken_m, fall_m;
   logic [LW-1:0]    n_taken, n_active;
   logic [PC_W-1:0]  fall_pc;
   logic             push_r, push_f, push_t;
   logic [SW-1:0]    base, pos_r, pos_f, pos_t, new_cnt;

   assign taken_m = br_lane_cond & top_mask;
   assign fall_m  = top_mask & ~taken_m;
   assign fall_pc = top_pc + PC_W'(1);

   simt_rs_popcnt #(.N(LANES)) u_pc_taken  (.vec(taken_m),  .cnt(n_taken));
   simt_rs_popcnt #(.N(LANES)) u_pc_active (.vec(top_mask), .cnt(n_active));

   assign push_r = (top_rpc != br_ipdom);
   assign push_f = (fall_pc != br_ipdom) && (n_taken < n_active);
   assign push_t = (br_target != br_ipdom) && (n_taken != '0);

   assign base    = SW'(cnt_q) - SW'(1);
   assign pos_r   = base;
   assign pos_f   = pos_r + SW'(push_r);
   assign pos_t   = pos_f + SW'(push_f);
   assign new_cnt = pos_t + SW'(push_t);

   always_comb begin
      wr_en   = '0;
      wr_idx  = '0;
      wr_pc   = '0;
      wr_rpc  = '0;
      wr_mask = '0;
      cnt_en  = 1'b0;
      cnt_d   = cnt_q;
      ovf_evt = 1'b0;
      unf_evt = 1'b0;
      bad_evt = 1'b0;
      if (br_valid && !br_cond) begin
         if (br_target == top_rpc) begin
            if (cnt_q == CW'(1)) unf_evt = 1'b1;
            else begin
               cnt_en = 1'b1;
               cnt_d  = cnt_q - CW'(1);
            end
         end else begin
            wr_en[WP_REJOIN]   = 1'b1;
            wr_idx[WP_REJOIN]  = base[IW-1:0];
            wr_pc[WP_REJOIN]   = br_target;
            wr_rpc[WP_REJOIN]  = top_rpc;
            wr_mask[WP_REJOIN] = top_mask;
         end
      end else if (br_valid && br_cond) begin
         if (br_target == fall_pc) bad_evt = 1'b1;
         else if (new_cnt == '0) unf_evt = 1'b1;
         else if (new_cnt > SW'(DEPTH)) ovf_evt = 1'b1;
         else begin
            cnt_en = 1'b1;
            cnt_d  = new_cnt[CW-1:0];
            wr_en[WP_REJOIN]   = push_r;
            wr_idx[WP_REJOIN]  = pos_r[IW-1:0];
            wr_pc[WP_REJOIN]   = br_ipdom;
            wr_rpc[WP_REJOIN]  = top_rpc;
            wr_mask[WP_REJOIN] = top_mask;
            wr_en[WP_FALL]     = push_f;
            wr_idx[WP_FALL]    = pos_f[IW-1:0];
            wr_pc[WP_FALL]     = fall_pc;
            wr_rpc[WP_FALL]    = br_ipdom;
            wr_mask[WP_FALL]   = fall_m;
            wr_en[WP_TAKEN]    = push_t;
            wr_idx[WP_TAKEN]   = pos_t[IW-1:0];
            wr_pc[WP_TAKEN]    = br_target;
            wr_rpc[WP_TAKEN]   = br_ipdom;
            wr_mask[WP_TAKEN]  = taken_m;
         end
      end
   end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
   import simt_rs_pkg::*;
#(
   parameter int unsigned LANES = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned PC_W  = 32,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  reset_pc,
   input  logic             br_valid,
   input  logic             br_cond,
   input  logic [PC_W-1:0]  br_target,
   input  logic [PC_W-1:0]  br_ipdom,
   input  logic [LANES-1:0] br_lane_cond,
   output logic [PC_W-1:0]  cur_pc,
   output logic [PC_W-1:0]  cur_rpc,
   output logic [LANES-1:0] cur_mask,
   output logic             discard_fetch,
   output logic             bad_branch,
   output logic             overflow,
   output logic             underflow
);
   if (LANES < 1 || DEPTH < 2 || PC_W < 2) begin : g_bad_param
      $error("simt_reconv_stack: LANES>=1, DEPTH>=2, PC_W>=2 required");
   end

   logic [WR_PORTS-1:0]            wr_en;
   logic [WR_PORTS-1:0][IW-1:0]    wr_idx;
   logic [WR_PORTS-1:0][PC_W-1:0]  wr_pc, wr_rpc;
   logic [WR_PORTS-1:0][LANES-1:0] wr_mask;
   logic                           cnt_en;
   logic [CW-1:0]                  cnt_d, cnt_q;
   logic                           ovf_evt, unf_evt, bad_evt;

   simt_rs_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_ctrl (
      .br_valid(br_valid), .br_cond(br_cond), .br_target(br_target),
      .br_ipdom(br_ipdom), .br_lane_cond(br_lane_cond), .cnt_q(cnt_q),
      .top_pc(cur_pc), .top_rpc(cur_rpc), .top_mask(cur_mask),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc), .wr_rpc(wr_rpc),
      .wr_mask(wr_mask), .cnt_en(cnt_en), .cnt_d(cnt_d),
      .ovf_evt(ovf_evt), .unf_evt(unf_evt), .bad_evt(bad_evt)
   );

   simt_rs_store #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_store (
      .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc), .wr_rpc(wr_rpc),
      .wr_mask(wr_mask), .cnt_en(cnt_en), .cnt_d(cnt_d), .cnt_q(cnt_q),
      .top_pc(cur_pc), .top_rpc(cur_rpc), .top_mask(cur_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         discard_fetch <= 1'b0;
         bad_branch    <= 1'b0;
         overflow      <= 1'b0;
         underflow     <= 1'b0;
      end else begin
         discard_fetch <= br_valid;
         bad_branch    <= bad_evt;
         if (ovf_evt) overflow  <= 1'b1;
         if (unf_evt) underflow <= 1'b1;
      end
   end
endmodule

// File: rtl/simt_rs_chk.sv
module simt_rs_chk #(
   parameter int unsigned LANES = 32,
   parameter int unsigned PC_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             br_valid,
   input logic             br_cond,
   input logic [PC_W-1:0]  br_target,
   input logic [PC_W-1:0]  br_ipdom,
   input logic [LANES-1:0] br_lane_cond,
   input logic [PC_W-1:0]  cur_pc,
   input logic [PC_W-1:0]  cur_rpc,
   input logic [LANES-1:0] cur_mask,
   input logic             discard_fetch,
   input logic             bad_branch,
   input logic             overflow,
   input logic             underflow
);
   // R8
   p_discard_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |=> discard_fetch);
   p_discard_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |=> !discard_fetch);
   // R2
   p_jump_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !br_cond && br_target != cur_rpc) |=>
      (cur_pc == $past(br_target) && cur_rpc == $past(cur_rpc)
       && cur_mask == $past(cur_mask)));
   // R6 / R5
   p_taken_on_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_cond && br_target != cur_pc + PC_W'(1)
       && br_target != br_ipdom && (br_lane_cond & cur_mask) != '0) |=>
      ($rose(overflow) || (cur_pc == $past(br_target)
       && cur_rpc == $past(br_ipdom)
       && cur_mask == $past(br_lane_cond & cur_mask))));
   // R9
   p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_cond && br_target == cur_pc + PC_W'(1)) |=>
      (bad_branch && $stable(cur_pc) && $stable(cur_rpc) && $stable(cur_mask)));
   p_no_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |=> !bad_branch);
   // R10
   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   p_ovf_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> ($stable(cur_pc) && $stable(cur_rpc) && $stable(cur_mask)));
   // R11
   p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);
   p_unf_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> ($stable(cur_pc) && $stable(cur_rpc) && $stable(cur_mask)));
endmodule

bind simt_reconv_stack simt_rs_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_cond(br_cond),
   .br_target(br_target), .br_ipdom(br_ipdom), .br_lane_cond(br_lane_cond),
   .cur_pc(cur_pc), .cur_rpc(cur_rpc), .cur_mask(cur_mask),
   .discard_fetch(discard_fetch), .bad_branch(bad_branch),
   .overflow(overflow), .underflow(underflow)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb;
   localparam int unsigned LANES = 8;
   localparam int unsigned DEPTH = 4;
   localparam int unsigned PC_W  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [PC_W-1:0]  reset_pc = 16'h0100;
   logic             br_valid = 1'b0, br_cond = 1'b0;
   logic [PC_W-1:0]  br_target = '0, br_ipdom = '0;
   logic [LANES-1:0] br_lane_cond = '0;
   logic [PC_W-1:0]  cur_pc, cur_rpc;
   logic [LANES-1:0] cur_mask;
   logic             discard_fetch, bad_branch, overflow, underflow;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   simt_reconv_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reset_pc(reset_pc), .br_valid(br_valid),
      .br_cond(br_cond), .br_target(br_target), .br_ipdom(br_ipdom),
      .br_lane_cond(br_lane_cond), .cur_pc(cur_pc), .cur_rpc(cur_rpc),
      .cur_mask(cur_mask), .discard_fetch(discard_fetch),
      .bad_branch(bad_branch), .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_top(input string req, input logic [15:0] pc,
                          input logic [15:0] rpc, input logic [7:0] m);
      chk({req, " pc"}, 32'(cur_pc), 32'(pc));
      chk({req, " rpc"}, 32'(cur_rpc), 32'(rpc));
      chk({req, " mask"}, 32'(cur_mask), 32'(m));
   endtask

   // drive at a falling edge, let one rising edge pass, sample at the next falling edge
   task automatic branch(input logic c, input logic [15:0] tgt,
                         input logic [15:0] ipd, input logic [7:0] lanes);
      @(negedge clk);
      br_valid = 1'b1; br_cond = c; br_target = tgt;
      br_ipdom = ipd; br_lane_cond = lanes;
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk_top("R1 reset", 16'h0100, 16'hFFFF, 8'hFF);
      chk("R1 discard", 32'(discard_fetch), 0);
      chk("R1 flags", 32'({bad_branch, overflow, underflow}), 0);
   endtask

   task automatic t_jump();
      branch(1'b0, 16'h0120, 16'h0, 8'h0);
      chk_top("R2 jump", 16'h0120, 16'hFFFF, 8'hFF);
      chk("R8 discard after jump", 32'(discard_fetch), 1);
      idle();
      chk("R8 discard drops", 32'(discard_fetch), 0);
   endtask

   task automatic t_split();
      branch(1'b1, 16'h0140, 16'h0130, 8'h0F);
      chk_top("R5 R6 taken top", 16'h0140, 16'h0130, 8'h0F);
      chk("R8 discard after cond", 32'(discard_fetch), 1);
      branch(1'b0, 16'h0130, 16'h0, 8'h0);
      chk_top("R3 R6 fall below", 16'h0121, 16'h0130, 8'hF0);
      branch(1'b0, 16'h0130, 16'h0, 8'h0);
      chk_top("R4 rejoin record", 16'h0130, 16'hFFFF, 8'hFF);
   endtask

   task automatic t_all_taken();
      branch(1'b1, 16'h0150, 16'h0160, 8'hFF);
      chk_top("R7 all taken top", 16'h0150, 16'h0160, 8'hFF);
      branch(1'b0, 16'h0160, 16'h0, 8'h0);
      chk_top("R7 no fall record", 16'h0160, 16'hFFFF, 8'hFF);
   endtask

   task automatic t_none_taken();
      branch(1'b1, 16'h0170, 16'h0180, 8'h00);
      chk_top("R7 none taken", 16'h0161, 16'h0180, 8'hFF);
      branch(1'b0, 16'h0180, 16'h0, 8'h0);
      chk_top("R7 none taken rejoin", 16'h0180, 16'hFFFF, 8'hFF);
   endtask

   task automatic t_nested_same_ipdom();
      branch(1'b1, 16'h0190, 16'h01A0, 8'h03);
      chk_top("R6 outer taken", 16'h0190, 16'h01A0, 8'h03);
      branch(1'b1, 16'h0198, 16'h01A0, 8'h01);
      chk_top("R5 inner taken", 16'h0198, 16'h01A0, 8'h01);
      branch(1'b0, 16'h01A0, 16'h0, 8'h0);
      chk_top("R5 inner fall", 16'h0191, 16'h01A0, 8'h02);
      branch(1'b0, 16'h01A0, 16'h0, 8'h0);
      chk_top("R4 no extra rejoin", 16'h0181, 16'h01A0, 8'hFC);
      branch(1'b0, 16'h01A0, 16'h0, 8'h0);
      chk_top("R3 back to base", 16'h01A0, 16'hFFFF, 8'hFF);
   endtask

   task automatic t_illegal();
      branch(1'b1, 16'h01A1, 16'h01B0, 8'h0F);
      chk("R9 bad pulse", 32'(bad_branch), 1);
      chk("R8 discard on illegal", 32'(discard_fetch), 1);
      chk_top("R9 unchanged", 16'h01A0, 16'hFFFF, 8'hFF);
      idle();
      chk("R9 bad drops", 32'(bad_branch), 0);
   endtask

   task automatic t_overflow();
      branch(1'b1, 16'h01C0, 16'h01B0, 8'h0F);
      chk_top("R6 pre-overflow", 16'h01C0, 16'h01B0, 8'h0F);
      chk("R10 clear before", 32'(overflow), 0);
      branch(1'b1, 16'h01D0, 16'h01C8, 8'h05);
      chk("R10 overflow set", 32'(overflow), 1);
      chk_top("R10 unchanged", 16'h01C0, 16'h01B0, 8'h0F);
      branch(1'b0, 16'h01B0, 16'h0, 8'h0);
      chk("R10 sticky", 32'(overflow), 1);
      chk_top("R10 stack intact", 16'h01A1, 16'h01B0, 8'hF0);
   endtask

   task automatic t_underflow();
      branch(1'b0, 16'h01B0, 16'h0, 8'h0);
      chk_top("R11 last record", 16'h01B0, 16'hFFFF, 8'hFF);
      chk("R11 clear before", 32'(underflow), 0);
      branch(1'b0, 16'hFFFF, 16'h0, 8'h0);
      chk("R11 underflow set", 32'(underflow), 1);
      chk_top("R11 unchanged", 16'h01B0, 16'hFFFF, 8'hFF);
      branch(1'b0, 16'h01B8, 16'h0, 8'h0);
      chk("R11 sticky", 32'(underflow), 1);
      chk_top("R2 jump after underflow", 16'h01B8, 16'hFFFF, 8'hFF);
   endtask

   initial begin
      #1000000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_jump();
      t_split();
      t_all_taken();
      t_none_taken();
      t_nested_same_ipdom();
      t_illegal();
      t_overflow();
      t_underflow();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule